// File: doc/BRIEF.md
# Stereo Gain, Routing and Zero-Run Mute Stage

This stage sits between a serial audio receiver and the oversampling filter of a stereo converter. Each accepted sample pair is scaled by a per-channel 8-bit gain code and then routed to the two outputs. Each output can be silent, take the right input, take the left input, or take the average of both. A soft mute moves the effective gain towards silence, or back towards full gain, by one step per accepted sample. This avoids an abrupt jump in level.

A zero-run detector counts bit-clock ticks while no nonzero input arrives. When the count reaches the run limit and zero detection is enabled, both outputs are forced to bipolar zero (code 0) at once. An active-low flag is driven while this happens. A separate disable control also forces both outputs to zero, whatever the input data.

Top module: `stereo_gain_router`

## Requirements
- R1: Code x (0..254) gives gain y = x/256, and code 255 gives y = 256/256. The scaled value is floor(sample*y_eff/256). Code 0 yields 0.
- R2: An applied gain code is replaced by its input code on each clock where that channel's load bit is 1. While the load bit is 0, changes on the code input have no effect on the output.
- R3: While gain_shared is 1, the left applied code scales both channels and the right code is ignored.
- R4: route_sel[3:2] picks the left output source and route_sel[1:0] picks the right output source. Each 2-bit field is decoded as 00 silent, 01 right, 10 left, 11 average. So 1001 is normal stereo, 0110 is swapped and 1111 is mono.
- R5: The average is floor((L'+R')/2) of the two scaled samples. It is formed with one extra bit, so it never overflows.
- R6: A ramp value r (0..256, reset 256) steps by 1 per accepted sample. It steps down while mute_req is 1 and up otherwise, and it saturates at both ends. The effective gain is y_eff = floor(y*r/256), and r is taken before that sample's step.
- R7: The zero-run counter clears on any accepted sample with a nonzero channel. Otherwise it counts bit_tick pulses and saturates at 65,536. While it is full and zdet_en is 1, both outputs are 0 and zero_flag_n is 0, with no cycle of delay.
- R8: While zdet_en is 0, zero_flag_n stays 1 and zero input causes no forced silence.
- R9: While out_disable is 1, both outputs are 0 in the same cycle, regardless of the input data.
- R10: Outputs are registered one clock after a smp_valid cycle, and out_valid pulses with them. After reset the outputs are 0, out_valid is 0, zero_flag_n is 1 and both applied codes are 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair accepted this cycle |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| bit_tick | input | 1 | One pulse per serial bit clock |
| gain_l_code | input | 8 | Left gain code |
| gain_l_load | input | 1 | Apply left gain code |
| gain_r_code | input | 8 | Right gain code |
| gain_r_load | input | 1 | Apply right gain code |
| gain_shared | input | 1 | Left code scales both channels |
| route_sel | input | 4 | Output routing selection |
| mute_req | input | 1 | Soft mute request |
| out_disable | input | 1 | Force both outputs to zero |
| zdet_en | input | 1 | Enable zero-run mute |
| out_valid | output | 1 | Output pair updated |
| out_left | output | 18 | Left output sample |
| out_right | output | 18 | Right output sample |
| zero_flag_n | output | 1 | Low while the zero-run mute is active |

## Verification
Processed samples are due on the first clock edge after their smp_valid cycle. Gain loads and ramp steps affect only samples accepted after the edge that records them. The disable and zero-run silencing act combinationally, in the same cycle as their cause. The bench drives inputs and samples outputs at the falling edge. It advances its reference model by exactly one rising edge before each comparison, so every result is checked in the cycle it is due. A boundary test places the zero-run limit at exactly 65,535 and 65,536 ticks.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
  typedef enum logic [1:0] {
    SRC_SILENT = 2'b00,
    SRC_RIGHT  = 2'b01,
    SRC_LEFT   = 2'b10,
    SRC_BLEND  = 2'b11
  } route_src_e;
endpackage

// File: rtl/sgr_gain_ctl.sv
module sgr_gain_ctl #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_l,
  input  logic              load_l,
  input  logic [CODE_W-1:0] code_r,
  input  logic              load_r,
  input  logic              shared,
  input  logic              mute_req,
  input  logic              step,
  output logic [CODE_W:0]   eff_l,
  output logic [CODE_W:0]   eff_r,
  output logic [CODE_W-1:0] app_l,
  output logic [CODE_W-1:0] app_r,
  output logic [CODE_W:0]   ramp
);
  localparam int GAIN_W = CODE_W + 1;
  localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1) << CODE_W;

  // code to linear gain numerator: all-ones code maps to exact unity
  function automatic logic [GAIN_W-1:0] code_to_y(input logic [CODE_W-1:0] c);
    return (&c) ? FULL : {1'b0, c};
  endfunction

  // soft-mute ramp applied on top of the code gain
  function automatic logic [GAIN_W-1:0] blend(input logic [GAIN_W-1:0] y,
                                              input logic [GAIN_W-1:0] r);
    logic [2*GAIN_W-1:0] p;
    p = y * r;
    return p[CODE_W +: GAIN_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_l <= '1;
      app_r <= '1;
      ramp  <= FULL;
    end else begin
      if (load_l) app_l <= code_l;
      if (load_r) app_r <= code_r;
      if (step) begin
        if (mute_req) ramp <= (ramp == '0) ? '0 : ramp - 1'b1;
        else          ramp <= (ramp == FULL) ? FULL : ramp + 1'b1;
      end
    end
  end

  always_comb begin
    eff_l = blend(code_to_y(app_l), ramp);
    eff_r = blend(code_to_y(shared ? app_l : app_r), ramp);
  end
endmodule

// File: rtl/sgr_zero_run.sv
module sgr_zero_run #(
  parameter int DATA_W   = 18,
  parameter int ZERO_RUN = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_left,
  input  logic [DATA_W-1:0] smp_right,
  input  logic              bit_tick,
  output logic              run_full
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] run_cnt;
  logic             seen_nonzero;

  assign seen_nonzero = smp_valid & ((|smp_left) | (|smp_right));

  always_ff @(posedge clk) begin
    if (!rst_n)                          run_cnt <= '0;
    else if (seen_nonzero)               run_cnt <= '0;
    else if (bit_tick && run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
  end

  assign run_full = (run_cnt == LIMIT);
endmodule

// File: rtl/sgr_mix_path.sv
module sgr_mix_path
  import sgr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_left,
  input  logic signed [DATA_W-1:0] smp_right,
  input  logic [CODE_W:0]          eff_l,
  input  logic [CODE_W:0]          eff_r,
  input  logic [3:0]               route_sel,
  output logic signed [DATA_W-1:0] q_left,
  output logic signed [DATA_W-1:0] q_right,
  output logic                     q_valid
);
  localparam int GAIN_W = CODE_W + 1;
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  // floor(s * g / 2^CODE_W)
  function automatic logic signed [DATA_W-1:0] scale(input logic signed [DATA_W-1:0] s,
                                                     input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = s * $signed({1'b0, g});
    return p[CODE_W +: DATA_W];
  endfunction

  // floor((a + b) / 2) with one guard bit
  function automatic logic signed [DATA_W-1:0] halve_sum(input logic signed [DATA_W-1:0] a,
                                                         input logic signed [DATA_W-1:0] b);
    logic signed [DATA_W:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    return s[DATA_W:1];
  endfunction

  logic signed [DATA_W-1:0] sc   [2];
  logic signed [DATA_W-1:0] pick [2];
  logic signed [DATA_W-1:0] avg;
  logic [GAIN_W-1:0]        gain [2];
  logic signed [DATA_W-1:0] din  [2];

  assign gain[0] = eff_l;
  assign gain[1] = eff_r;
  assign din[0]  = smp_left;
  assign din[1]  = smp_right;
  assign avg     = halve_sum(sc[0], sc[1]);

  // channel 0 = left output (route_sel[3:2]), channel 1 = right output (route_sel[1:0])
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    route_src_e src;
    assign src    = route_src_e'(route_sel[2*(1-ch) +: 2]);
    assign sc[ch] = scale(din[ch], gain[ch]);
    always_comb begin
      unique case (src)
        SRC_SILENT: pick[ch] = '0;
        SRC_RIGHT:  pick[ch] = sc[1];
        SRC_LEFT:   pick[ch] = sc[0];
        default:    pick[ch] = avg;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_left  <= '0;
      q_right <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= smp_valid;
      if (smp_valid) begin
        q_left  <= pick[0];
        q_right <= pick[1];
      end
    end
  end
endmodule

// File: rtl/stereo_gain_router.sv
module stereo_gain_router #(
  parameter int DATA_W   = 18,
  parameter int CODE_W   = 8,
  parameter int ZERO_RUN = 65536
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_left,
  input  logic signed [DATA_W-1:0] smp_right,
  input  logic                     bit_tick,
  input  logic [CODE_W-1:0]        gain_l_code,
  input  logic                     gain_l_load,
  input  logic [CODE_W-1:0]        gain_r_code,
  input  logic                     gain_r_load,
  input  logic                     gain_shared,
  input  logic [3:0]               route_sel,
  input  logic                     mute_req,
  input  logic                     out_disable,
  input  logic                     zdet_en,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     zero_flag_n
);
  logic [CODE_W:0]          eff_l, eff_r, ramp;
  logic [CODE_W-1:0]        app_l, app_r;
  logic                     run_full, zero_hit, force_zero;
  logic signed [DATA_W-1:0] q_left, q_right;

  sgr_gain_ctl #(.CODE_W(CODE_W)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .code_l(gain_l_code), .load_l(gain_l_load),
    .code_r(gain_r_code), .load_r(gain_r_load),
    .shared(gain_shared), .mute_req(mute_req), .step(smp_valid),
    .eff_l(eff_l), .eff_r(eff_r), .app_l(app_l), .app_r(app_r), .ramp(ramp)
  );

  sgr_zero_run #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .bit_tick(bit_tick), .run_full(run_full)
  );

  sgr_mix_path #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_path (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .eff_l(eff_l), .eff_r(eff_r), .route_sel(route_sel),
    .q_left(q_left), .q_right(q_right), .q_valid(out_valid)
  );

  assign zero_hit    = zdet_en & run_full;
  assign force_zero  = out_disable | zero_hit;
  assign out_left    = force_zero ? '0 : q_left;
  assign out_right   = force_zero ? '0 : q_right;
  assign zero_flag_n = ~zero_hit;
endmodule

// File: rtl/sgr_checker.sv
module sgr_checker #(
  parameter int DATA_W = 18,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic signed [DATA_W-1:0] smp_left,
  input logic signed [DATA_W-1:0] smp_right,
  input logic                     gain_l_load,
  input logic                     gain_r_load,
  input logic                     out_disable,
  input logic                     zdet_en,
  input logic [CODE_W-1:0]        app_l,
  input logic [CODE_W-1:0]        app_r,
  input logic [CODE_W:0]          ramp,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic                     zero_flag_n
);
  localparam logic [CODE_W:0] FULL = (CODE_W+1)'(1) << CODE_W;

  a_r9_disable_silences: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> (out_left == '0 && out_right == '0));

  a_r7_flag_silences: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_flag_n |-> (out_left == '0 && out_right == '0));

  a_r8_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !zdet_en |-> zero_flag_n);

  a_r7_nonzero_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_left != '0 || smp_right != '0)) |=> zero_flag_n);

  a_r2_left_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_l_load |=> $stable(app_l));

  a_r2_right_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_r_load |=> $stable(app_r));

  a_r6_ramp_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp == $past(ramp)) || (ramp == $past(ramp) + 1'b1) || (ramp + 1'b1 == $past(ramp)));

  a_r6_ramp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ramp <= FULL);

  a_r6_ramp_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(ramp));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
endmodule

bind stereo_gain_router sgr_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .smp_left(smp_left), .smp_right(smp_right),
  .gain_l_load(gain_l_load), .gain_r_load(gain_r_load),
  .out_disable(out_disable), .zdet_en(zdet_en),
  .app_l(app_l), .app_r(app_r), .ramp(ramp),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
  .zero_flag_n(zero_flag_n)
);

// File: tb/sim_stereo_gain_router.sv
module sim_stereo_gain_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [17:0] smp_left = '0, smp_right = '0;
  logic bit_tick = 1'b0;
  logic [7:0] gain_l_code = 8'hFF, gain_r_code = 8'hFF;
  logic gain_l_load = 1'b0, gain_r_load = 1'b0, gain_shared = 1'b0;
  logic [3:0] route_sel = 4'b1001;
  logic mute_req = 1'b0, out_disable = 1'b0, zdet_en = 1'b0;
  logic out_valid, zero_flag_n;
  logic signed [17:0] out_left, out_right;

  always #5 clk = ~clk;

  stereo_gain_router u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .bit_tick(bit_tick),
    .gain_l_code(gain_l_code), .gain_l_load(gain_l_load),
    .gain_r_code(gain_r_code), .gain_r_load(gain_r_load),
    .gain_shared(gain_shared), .route_sel(route_sel),
    .mute_req(mute_req), .out_disable(out_disable), .zdet_en(zdet_en),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .zero_flag_n(zero_flag_n)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string tag = "R10";

  // reference state
  int m_app_l = 255, m_app_r = 255, m_ramp = 256, m_cnt = 0;
  int m_ql = 0, m_qr = 0;
  bit m_qv = 1'b0;

  function automatic int y_of(int c);
    return (c == 255) ? 256 : c;
  endfunction

  function automatic int floor_div(longint num, longint den);
    if (num >= 0) return int'(num / den);
    return -int'(((-num) + den - 1) / den);
  endfunction

  function automatic int route_pick(int sel, int l, int r);
    case (sel)
      0: return 0;
      1: return r;
      2: return l;
      default: return floor_div(longint'(l) + longint'(r), 2);
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int gl, gr, sl, sr, nl, nr, na;
    bit nz;
    nl = m_app_l; nr = m_app_r; na = m_ramp;
    if (smp_valid) begin
      gl = floor_div(longint'(y_of(m_app_l)) * m_ramp, 256);
      gr = floor_div(longint'(y_of(gain_shared ? m_app_l : m_app_r)) * m_ramp, 256);
      sl = floor_div(longint'(int'(smp_left)) * gl, 256);
      sr = floor_div(longint'(int'(smp_right)) * gr, 256);
      m_ql = route_pick(int'(route_sel[3:2]), sl, sr);
      m_qr = route_pick(int'(route_sel[1:0]), sl, sr);
      if (mute_req) na = (m_ramp > 0) ? m_ramp - 1 : 0;
      else          na = (m_ramp < 256) ? m_ramp + 1 : 256;
    end
    m_qv = smp_valid;
    if (gain_l_load) nl = int'(gain_l_code);
    if (gain_r_load) nr = int'(gain_r_code);
    nz = smp_valid && (smp_left != 0 || smp_right != 0);
    if (nz) m_cnt = 0;
    else if (bit_tick && m_cnt < 65536) m_cnt++;
    m_app_l = nl; m_app_r = nr; m_ramp = na;
  endtask

  task automatic compare();
    bit zh;
    int el, er;
    zh = zdet_en && (m_cnt == 65536);
    el = (out_disable || zh) ? 0 : m_ql;
    er = (out_disable || zh) ? 0 : m_qr;
    chk(int'(out_left) == el, {tag, " left"}, int'(out_left), el);
    chk(int'(out_right) == er, {tag, " right"}, int'(out_right), er);
    chk(out_valid == m_qv, "R10 valid", int'(out_valid), int'(m_qv));
    chk(zero_flag_n == !zh, {tag, " flag"}, int'(zero_flag_n), int'(!zh));
  endtask

  task automatic cyc();
    @(negedge clk);
    model_edge();
    compare();
  endtask

  task automatic send(int l, int r);
    smp_left = 18'(l); smp_right = 18'(r); smp_valid = 1'b1;
    cyc();
    smp_valid = 1'b0;
    cyc();
  endtask

  task automatic expect_out(string req, int el, int er);
    chk(int'(out_left) == el, req, int'(out_left), el);
    chk(int'(out_right) == er, req, int'(out_right), er);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    tag = "R10";
    chk(out_left == 0 && out_right == 0, "R10 reset outputs", int'(out_left), 0);
    chk(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    chk(zero_flag_n == 1'b1, "R10 reset flag", int'(zero_flag_n), 1);
    rst_n = 1'b1;
    bit_tick = 1'b1;
    cyc();

    // R1: code mapping, default unity after reset
    tag = "R1";
    send(-7, 1000);
    expect_out("R1 unity code 255", -7, 1000);
    gain_l_code = 8'd128; gain_r_code = 8'd254; gain_l_load = 1'b1; gain_r_load = 1'b1;
    cyc();
    gain_l_load = 1'b0; gain_r_load = 1'b0;
    send(1000, 256);
    expect_out("R1 codes 128/254", 500, 254);
    send(-1001, -131072);
    expect_out("R1 negative floor", -501, -130048);
    gain_l_code = 8'd0; gain_r_code = 8'd1; gain_l_load = 1'b1; gain_r_load = 1'b1;
    cyc();
    gain_l_load = 1'b0; gain_r_load = 1'b0;
    send(131071, -1);
    expect_out("R1 code 0 silence, code 1", 0, -1);

    // R2: deferred load
    tag = "R2";
    gain_l_code = 8'd64; gain_r_code = 8'd32;
    send(4096, 4096);
    expect_out("R2 code ignored without load", 0, 16);
    gain_l_load = 1'b1;
    cyc();
    gain_l_load = 1'b0;
    gain_l_code = 8'd200;
    send(4096, 4096);
    expect_out("R2 left applied, right pending", 1024, 16);
    gain_r_load = 1'b1;
    cyc();
    gain_r_load = 1'b0;
    send(4096, 4096);
    expect_out("R2 right applied", 1024, 512);

    // R3: shared gain
    tag = "R3";
    gain_shared = 1'b1;
    send(4096, -4096);
    expect_out("R3 left code scales both", 1024, -1024);
    gain_shared = 1'b0;
    gain_l_code = 8'hFF; gain_r_code = 8'hFF; gain_l_load = 1'b1; gain_r_load = 1'b1;
    cyc();
    gain_l_load = 1'b0; gain_r_load = 1'b0;

    // R4/R5: every routing code
    for (int s = 0; s < 16; s++) begin
      tag = (s[1:0] == 2'b11 || s[3:2] == 2'b11) ? "R5" : "R4";
      route_sel = 4'(s);
      send(3, -4);
      send(-70001, 20000);
    end
    route_sel = 4'b1111;
    send(3, -4);
    expect_out("R5 average floor", -1, -1);
    route_sel = 4'b0110;
    send(10, 20);
    expect_out("R4 swapped", 20, 10);
    route_sel = 4'b1001;

    // R6: soft mute ramp
    tag = "R6";
    mute_req = 1'b1;
    for (int i = 0; i < 257; i++) send(1000, -1000);
    expect_out("R6 fully muted", 0, 0);
    mute_req = 1'b0;
    send(1000, -1000);
    send(1000, -1000);
    expect_out("R6 first ramp step up", 3, -4);
    for (int i = 0; i < 260; i++) send(1000, -1000);
    expect_out("R6 ramp back to unity", 1000, -1000);

    // R9: disable
    tag = "R9";
    out_disable = 1'b1;
    send(555, 666);
    expect_out("R9 disabled", 0, 0);
    out_disable = 1'b0;
    cyc();
    expect_out("R9 released", 555, 666);

    // R8: zero run with detection off
    tag = "R8";
    send(0, 0);
    for (int i = 0; i < 65600; i++) cyc();
    chk(zero_flag_n == 1'b1, "R8 flag high while disabled", int'(zero_flag_n), 1);
    expect_out("R8 no auto mute", 0, 0);
    send(0, 0);

    // R7: enabling with saturated run silences at once
    tag = "R7";
    route_sel = 4'b1001;
    zdet_en = 1'b1;
    #1;
    chk(zero_flag_n == 1'b0, "R7 immediate flag", int'(zero_flag_n), 0);
    cyc();
    bit_tick = 1'b0;
    send(77, 0);
    chk(zero_flag_n == 1'b1, "R7 nonzero releases", int'(zero_flag_n), 1);
    expect_out("R7 output resumes", 77, 0);
    bit_tick = 1'b1;
    for (int i = 0; i < 65535; i++) cyc();
    chk(zero_flag_n == 1'b1, "R7 65535 ticks not yet", int'(zero_flag_n), 1);
    expect_out("R7 65535 ticks output live", 77, 0);
    cyc();
    chk(zero_flag_n == 1'b0, "R7 65536 ticks flag low", int'(zero_flag_n), 0);
    expect_out("R7 65536 ticks silenced", 0, 0);
    zdet_en = 1'b0;
    cyc();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule